// File: doc/BRIEF.md
# Programmable One-Shot Countdown Timer with Interrupt

This block is a single-register countdown timer. Software writes one 32-bit control word that carries a 20-bit start count together with three command bits: one arms the count, one enables the interrupt and one acknowledges a pending interrupt. While armed, the counter steps down by one on every cycle in which the `tick` input is high. The tick itself comes from elsewhere on the chip.

When a tick takes the count from one to zero and the interrupt is enabled, a pending flag is set. That flag drives `irq` and also appears as bit 5 of an eight-bit interrupt status vector. The other seven status bits are passed straight through from the other interrupt sources. The counter then rests at zero until software loads it again. Reading the control port returns the live count and the two enable bits.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset the count is 0, both enable bits read 0 and `irq` is low.
- R2: A write with bit 24 set loads bits 19:0 into the count, sets the run bit (bit 24) and copies bit 25 into the interrupt-enable bit (bit 25). All of this is visible on `rd_data` in the cycle after the write.
- R3: A write with bit 24 clear leaves the count, the run bit and the interrupt-enable bit unchanged.
- R4: While the run bit is set and the count is nonzero, each cycle with `tick` high lowers the count by exactly one. A cycle with `tick` low leaves the count unchanged.
- R5: Once the count reaches zero it stays at zero under further ticks until a new load.
- R6: The pending flag is set only when a tick takes the count from 1 to 0 while interrupt enable is set. Loading a value of zero never sets it, and a transition with interrupt enable clear does not set it either.
- R7: A write with bit 26 set clears the pending flag in the next cycle. If a zero transition happens in the same cycle, the flag stays set.
- R8: When a load and a tick fall in the same cycle, the load wins and no decrement is applied.
- R9: `rd_data` shows the count in bits 19:0, the run bit in bit 24 and interrupt enable in bit 25. All other bits read 0.
- R10: `irq_status` bit 5 equals the pending flag. Every other bit equals the same bit of `irq_src`, with no delay.
- R11: `irq` equals the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: count, run, interrupt enable, acknowledge |
| rd_data | output | 32 | Readback of live count and enable bits |
| tick | input | 1 | Count-step enable, one step per high cycle |
| irq_src | input | 8 | Other interrupt sources (bit 5 unused) |
| irq_status | output | 8 | Merged interrupt status, bit 5 from this timer |
| irq | output | 1 | Timer interrupt request |

## Verification
The assertions place no restriction on `tick`, which may be high on any cycle, on consecutive cycles or never. `wr_en` may also coincide with a tick. They do assume that every input is a known level at each clock edge once reset is released. The stimulus drives every input on the falling edge, so values are settled before each rising edge. It keeps random load values small so that the count reaches zero often. It also mixes writes that have the acknowledge bit alone, the load bit alone, both bits, and neither bit, and it lets those writes land on tick cycles.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 20;
    localparam int STAT_W   = 8;
    localparam int RUN_BIT  = 24;
    localparam int IE_BIT   = 25;
    localparam int ACK_BIT  = 26;
    localparam int TMR_SLOT = 5;

    typedef struct packed {
        logic             load;
        logic             ack;
        logic             ie;
        logic [CNT_W-1:0] value;
    } cmd_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             ie;
        logic             pend;
    } tmr_state_t;
endpackage

// File: rtl/cdt_cmd_decode.sv
module cdt_cmd_decode
    import cdt_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output cmd_t              cmd
);
    always_comb begin
        cmd.load  = wr_en & wr_data[RUN_BIT];
        cmd.ack   = wr_en & wr_data[ACK_BIT];
        cmd.ie    = wr_data[IE_BIT];
        cmd.value = wr_data[CNT_W-1:0];
    end
endmodule

// File: rtl/cdt_core.sv
module cdt_core
    import cdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_t       cmd,
    input  logic       tick,
    output tmr_state_t st
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_t st_d, st_q;
    logic       step;
    logic       zero_event;

    always_comb begin
        st_d       = st_q;
        step       = tick && st_q.run && (st_q.cnt != '0) && !cmd.load;
        zero_event = step && (st_q.cnt == ONE) && st_q.ie;
        if (cmd.load) begin
            st_d.cnt = cmd.value;
            st_d.run = 1'b1;
            st_d.ie  = cmd.ie;
        end else if (step) begin
            st_d.cnt = st_q.cnt - ONE;
        end
        if (zero_event) begin
            st_d.pend = 1'b1;
        end else if (cmd.ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/cdt_status_merge.sv
module cdt_status_merge
    import cdt_pkg::*;
(
    input  logic [STAT_W-1:0] src,
    input  logic              tmr_pend,
    output logic [STAT_W-1:0] status
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == TMR_SLOT) begin : g_tmr
            assign status[i] = tmr_pend;
        end else begin : g_pass
            assign status[i] = src[i];
        end
    end
endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tick,
    input  logic [STAT_W-1:0] irq_src,
    output logic [STAT_W-1:0] irq_status,
    output logic              irq
);
    cmd_t       cmd;
    tmr_state_t st;

    cdt_cmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    cdt_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .tick  (tick),
        .st    (st)
    );

    cdt_status_merge u_merge (
        .src      (irq_src),
        .tmr_pend (st.pend),
        .status   (irq_status)
    );

    always_comb begin
        rd_data              = '0;
        rd_data[CNT_W-1:0]   = st.cnt;
        rd_data[RUN_BIT]     = st.run;
        rd_data[IE_BIT]      = st.ie;
    end

    assign irq = st.pend;
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
    import cdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              tick,
    input logic [STAT_W-1:0] irq_src,
    input logic [STAT_W-1:0] irq_status,
    input logic              irq
);
    logic             load;
    logic [CNT_W-1:0] cnt;
    assign load = wr_en && wr_data[RUN_BIT];
    assign cnt  = rd_data[CNT_W-1:0];

    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(wr_data[CNT_W-1:0])) && rd_data[RUN_BIT]);

    a_r3_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rd_data[IE_BIT]) && $stable(rd_data[RUN_BIT]));

    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && rd_data[RUN_BIT] && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

    a_r5_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> cnt == '0);

    a_r6_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[IE_BIT] && !irq) |=> !irq);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[ACK_BIT] && !tick) |=> !irq);

    a_r10_status_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[TMR_SLOT] == irq) &&
        ((irq_status & ~(STAT_W'(1) << TMR_SLOT)) == (irq_src & ~(STAT_W'(1) << TMR_SLOT))));
endmodule

bind countdown_irq_timer cdt_checker u_cdt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .tick       (tick),
    .irq_src    (irq_src),
    .irq_status (irq_status),
    .irq        (irq)
);

// File: tb/tb_countdown_irq_timer.sv
module tb_countdown_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick = 1'b0;
    logic [7:0]  irq_src = '0;
    logic [7:0]  irq_status;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [19:0] m_cnt;
    logic        m_run, m_ie, m_pend;

    always #4 clk = ~clk;

    countdown_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .irq_src(irq_src),
        .irq_status(irq_status), .irq(irq)
    );

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        r[19:0] = m_cnt;
        r[24]   = m_run;
        r[25]   = m_ie;
        return r;
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] s = irq_src;
        s[5] = m_pend;
        return s;
    endfunction

    task automatic check(string tag);
        n_tests++;
        if (rd_data !== exp_rd()) begin
            n_fail++;
            $display("FAIL %s/R9 rd_data actual %h expected %h", tag, rd_data, exp_rd());
        end
        n_tests++;
        if (irq !== m_pend) begin
            n_fail++;
            $display("FAIL %s/R11 irq actual %b expected %b", tag, irq, m_pend);
        end
        n_tests++;
        if (irq_status !== exp_status()) begin
            n_fail++;
            $display("FAIL %s/R10 irq_status actual %h expected %h", tag, irq_status, exp_status());
        end
    endtask

    // one clock: drive at negedge, update model at posedge, check at next negedge
    task automatic cycle(input logic w, input logic [31:0] d, input logic t,
                         input logic [7:0] src, input string tag);
        logic load, ack, step, ev;
        wr_en = w; wr_data = d; tick = t; irq_src = src;
        @(posedge clk);
        load = w && d[24];
        ack  = w && d[26];
        step = t && m_run && (m_cnt != 0) && !load;
        ev   = step && (m_cnt == 20'd1) && m_ie;
        if (load) begin
            m_cnt = d[19:0]; m_run = 1'b1; m_ie = d[25];
        end else if (step) begin
            m_cnt = m_cnt - 20'd1;
        end
        if (ev) m_pend = 1'b1;
        else if (ack) m_pend = 1'b0;
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [31:0] word(input logic run, input logic ie,
                                         input logic ack, input logic [19:0] v);
        logic [31:0] x = '0;
        x[19:0] = v; x[24] = run; x[25] = ie; x[26] = ack;
        return x;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd7;
        void'($urandom(seed));
        m_cnt = '0; m_run = 1'b0; m_ie = 1'b0; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: load 3 with interrupt enabled, then tick to zero (R4, R6)
        cycle(1'b1, word(1, 1, 0, 20'd3), 1'b0, 8'h00, "R2");
        cycle(1'b0, '0, 1'b0, 8'h00, "R4");
        for (int i = 0; i < 3; i++) cycle(1'b0, '0, 1'b1, 8'h00, "R6");
        // R5: further ticks keep zero
        for (int i = 0; i < 4; i++) cycle(1'b0, '0, 1'b1, 8'hDF, "R5");
        // R3: ack-only write leaves count/flags, clears pending (R7)
        cycle(1'b1, word(0, 0, 1, 20'hABCDE), 1'b0, 8'h21, "R7");
        cycle(1'b1, word(0, 0, 0, 20'h12345), 1'b1, 8'h00, "R3");
        // R6: load zero with enable never interrupts
        cycle(1'b1, word(1, 1, 0, 20'd0), 1'b0, 8'h00, "R6");
        for (int i = 0; i < 3; i++) cycle(1'b0, '0, 1'b1, 8'h00, "R6");
        // R6: interrupt disabled transition
        cycle(1'b1, word(1, 0, 0, 20'd1), 1'b0, 8'h00, "R6");
        cycle(1'b0, '0, 1'b1, 8'h00, "R6");
        // R8: load with tick same cycle
        cycle(1'b1, word(1, 1, 0, 20'd2), 1'b1, 8'h00, "R8");
        cycle(1'b1, word(1, 1, 0, 20'd1), 1'b1, 8'h00, "R8");
        // R7: ack coincides with zero event; event wins
        cycle(1'b1, word(0, 0, 1, 20'd0), 1'b1, 8'h00, "R7");
        cycle(1'b1, word(0, 0, 1, 20'd0), 1'b0, 8'h00, "R7");
        // R9: max value load, reserved bits stay zero
        cycle(1'b1, 32'hFFFF_FFFF & ~32'h0400_0000, 1'b0, 8'hFF, "R9");

        for (int i = 0; i < 3000; i++) begin
            logic w, t;
            logic [31:0] d;
            w = ($urandom % 6) == 0;
            t = ($urandom % 2) == 0;
            d = $urandom;
            d[19:0] = 20'($urandom % 12);
            cycle(w, d, t, 8'($urandom), "R4");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule